// File: doc/BRIEF.md
# Per-Line Interrupt Controller

This block collects up to 32 interrupt request lines and presents them to a processor core as a gated pending vector, one combined request, and the index of the most urgent pending line. Software configures it through a small register port: one register enables lines individually, one selects per line between active-high level sensing and rising-edge capture, and one shows the pending lines and clears captured edges. A 16-bit vector-table base register is held here as well, so the block that forms vector addresses can read it directly.

A level-mode line is pending in the same cycle that its input is high and its enable is set. An edge-mode line compares its input with the value registered on the previous clock. A rise sets a latch that stays set until software writes a 1 to that line's bit of the pending register. The combined request is qualified by a global enable input. When the core runs in vectored mode, a separate output marks that the priority index should be used to select a vector.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset the enable, pending and mode registers read 0, the base register reads 0x0000_0100, and `irq_req`, `prio_valid` and `vec_take` are 0.
- R2: For a line whose mode bit is 0, `pending_o[i]` equals `irq_in[i] & enable[i]` in the same cycle.
- R3: For a line whose mode bit is 1, an input that is 1 in a cycle and was 0 at the previous clock edge sets the line's capture latch at the next edge. From then on `pending_o[i]` reads the latch ANDed with `enable[i]`. The latch is set whether or not the line is enabled.
- R4: A set capture latch stays set after its input falls. It clears only when the pending register (address 1) is written with a 1 in that bit. Writing 0 to the bit has no effect.
- R5: Writing the pending register has no effect on lines in level mode.
- R6: `irq_req` is 1 exactly when `global_ie` is 1 and at least one bit of `pending_o` is 1.
- R7: `prio_idx` is the lowest-numbered set bit of `pending_o`, and `prio_valid` shows that any bit is set. With nothing pending, `prio_idx` is 0. Both follow the inputs in the same cycle.
- R8: The base register (address 3) keeps bits 15:0 of a write, drops the upper bits, reads back zero-extended, and drives `vec_base`.
- R9: `vec_take` equals `irq_req & vect_mode`.
- R10: Register map for `reg_addr`: 0 = enable, 1 = pending, 2 = mode (1 = rising edge, 0 = level), 3 = base. `reg_rdata` is a combinational read of the addressed register. Writes take effect at the clock edge where `reg_we` is 1.
- R11: If a rise and a clear of the same edge-mode line fall in the same cycle, the latch is set. A line in level mode holds its latch cleared, so switching a line back to edge mode starts with no stale event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines |
| global_ie | input | 1 | Global interrupt enable from the core |
| vect_mode | input | 1 | Core runs in vectored interrupt mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| pending_o | output | 32 | Gated pending vector |
| irq_req | output | 1 | Combined interrupt request |
| prio_idx | output | 5 | Index of lowest-numbered pending line |
| prio_valid | output | 1 | At least one line pending |
| vec_base | output | 16 | Vector-table base |
| vec_take | output | 1 | Vectored request is active |

## Verification
The lines are driven with sparse random toggles, so single rises, held highs, falls and multi-line overlaps all occur while enables, modes and clear masks are rewritten at random. This separates a level line that follows its input from an edge line that must keep its latch. Directed cases isolate the behaviours a random run may blur. A write-0 and a write-1 to the pending bit of a held edge event tell a real clear from a stray one. A clear write to an asserted level line shows that the write is ignored. A rise and a clear in the same cycle confirm which one wins. Dense and empty pending vectors, with `global_ie` and `vect_mode` varied, tell the lowest-index priority apart from other orderings and check the gating of the request outputs.

// File: rtl/irqc_pkg.sv
// Package: register addresses and shared constants of the interrupt controller.
package irqc_pkg;
    localparam int REG_ADDR_W = 2;
    typedef enum logic [REG_ADDR_W-1:0] {
        REG_ENABLE  = 2'd0,
        REG_PENDING = 2'd1,
        REG_MODE    = 2'd2,
        REG_BASE    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irqc_line_cell.sv
// One request line: registers the input, captures rising edges in edge mode,
// and presents the ungated active state. Assumes mode_i is stable register state.
module irqc_line_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic mode_i,
    input  logic clr_i,
    output logic active_o
);
    logic prev_q;
    logic lat_q;

    // Track previous input and hold captured edge events; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            lat_q  <= 1'b0;
        end else begin
            prev_q <= line_i;
            if (!mode_i)
                lat_q <= 1'b0;
            else if (line_i && !prev_q)
                lat_q <= 1'b1;
            else if (clr_i)
                lat_q <= 1'b0;
        end
    end

    // Select level or latched view of the line.
    always_comb active_o = mode_i ? lat_q : line_i;

    // R3: a rise seen in edge mode is captured at the next edge.
    p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && line_i && !prev_q) |=> lat_q);
    // R4: without a clear the captured event is held.
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && lat_q && !clr_i) |=> lat_q);
    // R11: level mode keeps the latch empty.
    p_level_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> !lat_q || $past(mode_i) == 1'b0 && mode_i);
endmodule

// File: rtl/irqc_prio.sv
// Priority encoder: returns the lowest-numbered set bit of the vector.
// Assumes IDX_W is wide enough to index N lines.
module irqc_prio #(
    parameter int N     = 32,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);
    // Scan from the top down so the lowest set index is assigned last.
    always_comb begin
        idx_o   = '0;
        valid_o = |vec_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    // R7: the reported line is pending and no lower line is.
    p_prio_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (vec_i[idx_o] && ((vec_i & ((N'(1) << idx_o) - N'(1))) == '0)));
    // R7: idle vector reports index zero.
    p_prio_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (idx_o == '0));
endmodule

// File: rtl/irqc_regs.sv
// Software register file: enable, mode and vector base, plus read mux and the
// pending-clear mask. Assumes NUM_LINES <= DATA_W and BASE_W <= DATA_W.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int              NUM_LINES = 32,
    parameter int              DATA_W    = 32,
    parameter int              BASE_W    = 16,
    parameter logic [BASE_W-1:0] BASE_RST = 16'h0100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [NUM_LINES-1:0]  pending_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic [NUM_LINES-1:0]  enable_o,
    output logic [NUM_LINES-1:0]  mode_o,
    output logic [NUM_LINES-1:0]  clr_o,
    output logic [BASE_W-1:0]     base_o
);
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] mode_q;
    logic [BASE_W-1:0]    base_q;

    // Apply software writes to the writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
            base_q <= BASE_RST;
        end else if (we_i) begin
            case (reg_sel_e'(addr_i))
                REG_ENABLE: en_q   <= wdata_i[NUM_LINES-1:0];
                REG_MODE:   mode_q <= wdata_i[NUM_LINES-1:0];
                REG_BASE:   base_q <= wdata_i[BASE_W-1:0];
                default:    ;
            endcase
        end
    end

    // Build the write-one-to-clear mask for the pending register.
    always_comb clr_o = (we_i && reg_sel_e'(addr_i) == REG_PENDING) ?
                        wdata_i[NUM_LINES-1:0] : '0;

    // Combinational read of the addressed register, zero-extended.
    always_comb begin
        case (reg_sel_e'(addr_i))
            REG_ENABLE:  rdata_o = DATA_W'(en_q);
            REG_PENDING: rdata_o = DATA_W'(pending_i);
            REG_MODE:    rdata_o = DATA_W'(mode_q);
            default:     rdata_o = DATA_W'(base_q);
        endcase
    end

    assign enable_o = en_q;
    assign mode_o   = mode_q;
    assign base_o   = base_q;

    // R1: leaving reset, configuration is at its reset values.
    p_cfg_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && mode_q == '0 && base_q == BASE_RST));
    // R10: registers change only on a write strobe.
    p_cfg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(en_q) && $stable(mode_q) && $stable(base_q)));
endmodule

// File: rtl/irq_line_ctrl.sv
// Top of the per-line interrupt controller: one capture cell per line, a
// register file, enable gating, request qualification and priority encoding.
// Assumes irq_in is synchronous to clk.
module irq_line_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int DATA_W    = 32,
    parameter int BASE_W    = 16,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  irq_in,
    input  logic                  global_ie,
    input  logic                  vect_mode,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_LINES-1:0]  pending_o,
    output logic                  irq_req,
    output logic [IDX_W-1:0]      prio_idx,
    output logic                  prio_valid,
    output logic [BASE_W-1:0]     vec_base,
    output logic                  vec_take
);
    logic [NUM_LINES-1:0] enable_w;
    logic [NUM_LINES-1:0] mode_w;
    logic [NUM_LINES-1:0] clr_w;
    logic [NUM_LINES-1:0] active_w;

    irqc_regs #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .BASE_W    (BASE_W),
        .BASE_RST  (BASE_W'(16'h0100))
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .pending_i (pending_o),
        .rdata_o   (reg_rdata),
        .enable_o  (enable_w),
        .mode_o    (mode_w),
        .clr_o     (clr_w),
        .base_o    (vec_base)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irqc_line_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_i   (irq_in[g]),
            .mode_i   (mode_w[g]),
            .clr_i    (clr_w[g]),
            .active_o (active_w[g])
        );
    end

    // Gate each active line with its enable bit.
    always_comb pending_o = active_w & enable_w;

    irqc_prio #(
        .N     (NUM_LINES),
        .IDX_W (IDX_W)
    ) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .vec_i   (pending_o),
        .idx_o   (prio_idx),
        .valid_o (prio_valid)
    );

    // Qualify the combined request and the vectored-take flag.
    always_comb begin
        irq_req  = prio_valid & global_ie;
        vec_take = irq_req & vect_mode;
    end

    // R2: no disabled line is ever reported pending.
    p_pend_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o & ~enable_w) == '0);
    // R6: a request needs the global enable and a pending line.
    p_req_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (global_ie && pending_o != '0));
    // R9: vectored take implies vectored mode and a request.
    p_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_take |-> (vect_mode && irq_req));
endmodule

// File: tb/irq_line_ctrl_bench.sv
`timescale 1ns/1ps
module irq_line_ctrl_bench;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        global_ie = 1'b0;
    logic        vect_mode = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] pending_o;
    logic        irq_req;
    logic [4:0]  prio_idx;
    logic        prio_valid;
    logic [15:0] vec_base;
    logic        vec_take;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [N-1:0] en_m, mode_m, lat_m, prev_m;
    logic [15:0]  base_m;

    irq_line_ctrl u_irq_line_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .global_ie(global_ie),
        .vect_mode(vect_mode), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pending_o(pending_o),
        .irq_req(irq_req), .prio_idx(prio_idx), .prio_valid(prio_valid),
        .vec_base(vec_base), .vec_take(vec_take)
    );

    always #2.5 clk = ~clk;

    function automatic logic [N-1:0] exp_pend();
        return ((mode_m & lat_m) | (~mode_m & irq_in)) & en_m;
    endfunction

    function automatic logic [4:0] exp_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return 5'(i);
        return 5'd0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return en_m;
            2'd1: return exp_pend();
            2'd2: return mode_m;
            default: return {16'h0, base_m};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic model_edge();
        logic [N-1:0] clr;
        if (!rst_n) begin
            en_m = '0; mode_m = '0; lat_m = '0; prev_m = '0; base_m = 16'h0100;
            return;
        end
        clr = (reg_we && reg_addr == 2'd1) ? reg_wdata : '0;
        for (int i = 0; i < N; i++) begin
            if (!mode_m[i]) lat_m[i] = 1'b0;
            else if (irq_in[i] && !prev_m[i]) lat_m[i] = 1'b1;
            else if (clr[i]) lat_m[i] = 1'b0;
        end
        prev_m = irq_in;
        if (reg_we) begin
            case (reg_addr)
                2'd0: en_m = reg_wdata;
                2'd2: mode_m = reg_wdata;
                2'd3: base_m = reg_wdata[15:0];
                default: ;
            endcase
        end
    endtask

    task automatic check_all();
        logic [N-1:0] p;
        p = exp_pend();
        check("R2 R3 R4 R5 pending", pending_o, p);
        check("R6 irq_req", 32'(irq_req), 32'(global_ie & (|p)));
        check("R7 prio_idx", 32'(prio_idx), 32'(exp_idx(p)));
        check("R7 prio_valid", 32'(prio_valid), 32'(|p));
        check("R9 vec_take", 32'(vec_take), 32'(global_ie & (|p) & vect_mode));
        check("R8 vec_base", 32'(vec_base), 32'(base_m));
        check("R10 rdata", reg_rdata, exp_read(reg_addr));
    endtask

    // One clock: update model at the edge, check at the following falling edge.
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] a, input logic [31:0] expv);
        reg_addr = a;
        #0.1;
        check(tag, reg_rdata, expv);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        tick(); tick();
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state.
        rd_check("R1 enable reset", 2'd0, 32'h0);
        rd_check("R1 pending reset", 2'd1, 32'h0);
        rd_check("R1 mode reset", 2'd2, 32'h0);
        rd_check("R1 base reset", 2'd3, 32'h0000_0100);
        check("R1 irq_req reset", 32'(irq_req), 32'h0);
        check("R1 prio_valid reset", 32'(prio_valid), 32'h0);
        check("R1 vec_take reset", 32'(vec_take), 32'h0);
        tick();

        // R8 base keeps only low 16 bits.
        wr(2'd3, 32'hABCD_1234);
        rd_check("R8 base upper dropped", 2'd3, 32'h0000_1234);

        // R2 level line passes through same cycle.
        global_ie = 1'b1; vect_mode = 1'b1;
        wr(2'd0, 32'hFFFF_FFFF);
        irq_in = 32'h0000_0008;
        #0.1;
        check("R2 level same cycle", pending_o, 32'h0000_0008);
        check("R9 vec_take directed", 32'(vec_take), 32'h1);
        // R5 clear write to level line ignored.
        wr(2'd1, 32'h0000_0008);
        check("R5 level clear ignored", pending_o, 32'h0000_0008);
        irq_in = '0;
        tick();

        // R3 R4 edge capture on line 5.
        wr(2'd2, 32'h0000_0020);
        irq_in[5] = 1'b1;
        tick();
        check("R3 edge captured", pending_o, 32'h0000_0020);
        irq_in[5] = 1'b0;
        tick();
        check("R4 held after fall", pending_o, 32'h0000_0020);
        wr(2'd1, 32'hFFFF_FFDF);
        check("R4 write0 no effect", pending_o, 32'h0000_0020);
        wr(2'd1, 32'h0000_0020);
        check("R4 write1 clears", pending_o, 32'h0000_0000);

        // R11 rise and clear in same cycle: set wins.
        irq_in[5] = 1'b1;
        wr(2'd1, 32'h0000_0020);
        check("R11 set beats clear", pending_o, 32'h0000_0020);
        irq_in[5] = 1'b0;
        // R11 back to level discards latch, then edge mode starts empty.
        wr(2'd2, 32'h0);
        wr(2'd2, 32'h0000_0020);
        check("R11 no stale event", pending_o, 32'h0000_0000);

        // R7 dense vector: lowest wins; R6 gated by global_ie.
        wr(2'd2, 32'h0);
        irq_in = 32'h8001_0400;
        #0.1;
        check("R7 lowest index", 32'(prio_idx), 32'd10);
        global_ie = 1'b0;
        #0.1;
        check("R6 global gate", 32'(irq_req), 32'h0);
        irq_in = '0;
        tick();

        // Random mix.
        for (int n = 0; n < 4000; n++) begin
            irq_in ^= ($urandom() & $urandom() & $urandom());
            global_ie = ($urandom_range(0, 7) != 0);
            vect_mode = $urandom_range(0, 1) == 1;
            reg_addr = 2'($urandom_range(0, 3));
            reg_we = ($urandom_range(0, 3) == 0);
            reg_wdata = $urandom();
            if (reg_we && reg_addr == 2'd1 && $urandom_range(0, 1) == 1)
                reg_wdata = 32'h0;
            tick();
        end
        reg_we = 1'b0;
        tick();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule